// File: doc/BRIEF.md
# Priority-Ordered Pin Crossbar

The block hands a chip's digital peripheral signals out to its general-purpose port pins. Seventeen signals are visited one after another in a fixed order of precedence. Each signal whose peripheral is switched on takes the lowest-numbered pin that is still free. A pin is free when software has not set its skip bit, when it exists on the package, and when no signal earlier in the order has already taken it. The pins form three ports of eight. Port 0 holds pins 0 to 7, port 1 holds pins 8 to 15 and port 2 holds pins 16 to 23. A pin's global index is port times 8 plus bit.

Because the allocation is a walk, one enable can move every signal after it. Switching a peripheral off lets all later signals shift down into the pins it freed. Pins that carry analog or dedicated functions are never detected by the block. Software must skip them. A parameter marks pins that are missing on the package, and those pins are treated as permanently skipped.

The result is given in two views, and both are registered. For each pin there is a source index and a valid flag. For each signal there is a pin index and a valid flag.

Top module: `pin_crossbar`

## Requirements
- R1: Source indices, in priority order, are: 0 UART transmit, 1 UART receive, 2 SPI clock, 3 SPI MISO, 4 SPI MOSI, 5 SPI select, 6 I2C data, 7 I2C clock, 8 comparator synchronous output, 9 comparator asynchronous output, 10 clock output, 11 to 13 PWM channels 0 to 2, 14 counter external clock, 15 timer 0 input, 16 timer 1 input. When two signals both hold pins, the one with the lower index always holds the lower pin.
- R2: Each requesting signal takes the lowest-numbered available pin not already taken by a signal earlier in the order. Pin index equals port*8 + bit, so the walk runs across port boundaries.
- R3: A pin whose bit is 1 in `skip_mask` (bit b of port p is `skip_mask[p][b]`) is never assigned.
- R4: A pin whose bit is set in the `ABSENT_PINS` parameter is never assigned. It is passed over exactly like a skipped pin.
- R5: The SPI select signal (index 5) requests a pin only when `spi_4wire` is 1. With `spi_4wire` at 0 it consumes no pin.
- R6: Enable groups work as follows. `uart_en` drives indices 0 and 1. `spi_en` drives 2, 3, 4 and 5. `i2c_en` drives 6 and 7. `pwm_cnt` = n enables the first n PWM channels, for n from 0 to 3. Every other signal has its own enable bit. A disabled signal takes no pin, and later signals fill the gap.
- R7: When a requesting signal finds no available pin left, its `sig_valid` is 0 and `overflow` is 1.
- R8: An unassigned pin shows source index 31 (all ones) with `pin_valid` 0. An unassigned signal shows `sig_pin` 0 with `sig_valid` 0.
- R9: Outputs are registered and reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all pins are unassigned, all signals are invalid and `overflow` is 0.
- R10: With `xbar_en` at 0, no pin is assigned and `overflow` is 0, whatever the other inputs.
- R11: The two views agree. A valid pin's source signal is valid and points back to that pin, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| uart_en | input | 1 | UART pair enable |
| spi_en | input | 1 | SPI group enable |
| spi_4wire | input | 1 | SPI select pinned out when 1 |
| i2c_en | input | 1 | I2C pair enable |
| cmp_en | input | 1 | Comparator synchronous output enable |
| cmp_async_en | input | 1 | Comparator asynchronous output enable |
| clkout_en | input | 1 | Clock output enable |
| pwm_cnt | input | 2 | Number of PWM channels routed (0 to 3) |
| cnt_clk_en | input | 1 | Counter external clock input enable |
| tmr0_en | input | 1 | Timer 0 input enable |
| tmr1_en | input | 1 | Timer 1 input enable |
| skip_mask | input | NUM_PORTS x PORT_W | Per-port skip bits |
| pin_src | output | NUM_PINS x 5 | Source index per pin, 31 when free |
| pin_valid | output | NUM_PINS | Pin carries a crossbar signal |
| sig_pin | output | 17 x PIN_W | Pin index per signal |
| sig_valid | output | 17 | Signal has a pin |
| overflow | output | 1 | A requesting signal found no pin |

## Verification
The assertions are checked on every cycle. They cover the following properties:
- the ordering property between every pair of placed signals;
- agreement between the pin and signal views;
- the all-ones code on free pins;
- that skipped and absent pins never carry a signal;
- that the select signal stays unplaced in 3-wire mode;
- that global disable empties the map;
- that an overflow happens only when every usable pin is already taken.

Other properties can only be shown by the bench's scenarios, which compare against a cursor-walk model. These cover:
- that each signal lands on exactly the lowest free pin;
- that later signals close up when a group is switched off;
- that the PWM count enables exactly its prefix;
- that a change in the inputs appears one edge later and not sooner.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
   localparam int unsigned SIG_COUNT = 17;
   localparam int unsigned SRC_W     = 5;
   localparam logic [SRC_W-1:0] SRC_NONE = '1;

   typedef enum logic [SRC_W-1:0] {
      SIG_UART_TX    = 5'd0,
      SIG_UART_RX    = 5'd1,
      SIG_SPI_CLK    = 5'd2,
      SIG_SPI_MISO   = 5'd3,
      SIG_SPI_MOSI   = 5'd4,
      SIG_SPI_SEL    = 5'd5,
      SIG_I2C_SDA    = 5'd6,
      SIG_I2C_SCL    = 5'd7,
      SIG_CMP_SYNC   = 5'd8,
      SIG_CMP_ASYNC  = 5'd9,
      SIG_CLK_OUT    = 5'd10,
      SIG_PWM0       = 5'd11,
      SIG_PWM1       = 5'd12,
      SIG_PWM2       = 5'd13,
      SIG_CNT_EXTCLK = 5'd14,
      SIG_TMR0_IN    = 5'd15,
      SIG_TMR1_IN    = 5'd16
   } sig_id_e;
endpackage

// File: rtl/pxb_req_decode.sv
module pxb_req_decode
   import pxb_pkg::*;
(
   input  logic                 xbar_en,
   input  logic                 uart_en,
   input  logic                 spi_en,
   input  logic                 spi_4wire,
   input  logic                 i2c_en,
   input  logic                 cmp_en,
   input  logic                 cmp_async_en,
   input  logic                 clkout_en,
   input  logic [1:0]           pwm_cnt,
   input  logic                 cnt_clk_en,
   input  logic                 tmr0_en,
   input  logic                 tmr1_en,
   output logic [SIG_COUNT-1:0] req
);
   logic [SIG_COUNT-1:0] raw;

   always_comb begin
      raw                 = '0;
      raw[SIG_UART_TX]    = uart_en;
      raw[SIG_UART_RX]    = uart_en;
      raw[SIG_SPI_CLK]    = spi_en;
      raw[SIG_SPI_MISO]   = spi_en;
      raw[SIG_SPI_MOSI]   = spi_en;
      raw[SIG_SPI_SEL]    = spi_en & spi_4wire;
      raw[SIG_I2C_SDA]    = i2c_en;
      raw[SIG_I2C_SCL]    = i2c_en;
      raw[SIG_CMP_SYNC]   = cmp_en;
      raw[SIG_CMP_ASYNC]  = cmp_async_en;
      raw[SIG_CLK_OUT]    = clkout_en;
      raw[SIG_PWM0]       = (pwm_cnt != 2'd0);
      raw[SIG_PWM1]       = (pwm_cnt >= 2'd2);
      raw[SIG_PWM2]       = (pwm_cnt == 2'd3);
      raw[SIG_CNT_EXTCLK] = cnt_clk_en;
      raw[SIG_TMR0_IN]    = tmr0_en;
      raw[SIG_TMR1_IN]    = tmr1_en;
   end

   assign req = raw & {SIG_COUNT{xbar_en}};
endmodule

// File: rtl/pxb_alloc.sv
module pxb_alloc
   import pxb_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned PIN_W    = 5
)(
   input  logic [SIG_COUNT-1:0]                 req,
   input  logic [NUM_PINS-1:0]                  avail,
   output logic [SIG_COUNT-1:0][NUM_PINS-1:0]   grant,
   output logic [SIG_COUNT-1:0][PIN_W-1:0]      sig_pin,
   output logic [SIG_COUNT-1:0]                 sig_ok,
   output logic                                 starved
);
   localparam logic [NUM_PINS-1:0] LSB_ONE = {{(NUM_PINS-1){1'b0}}, 1'b1};

   function automatic logic [PIN_W-1:0] oh_index(input logic [NUM_PINS-1:0] oh);
      logic [PIN_W-1:0] idx;
      idx = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (oh[i]) idx = idx | PIN_W'(i);
      end
      return idx;
   endfunction

   logic [SIG_COUNT:0][NUM_PINS-1:0] free_at;
   logic [SIG_COUNT-1:0]             miss;

   assign free_at[0] = avail;

   for (genvar k = 0; k < SIG_COUNT; k++) begin : g_stage
      logic [NUM_PINS-1:0] lowest;
      logic [NUM_PINS-1:0] pick;
      assign lowest        = free_at[k] & (~free_at[k] + LSB_ONE);
      assign pick          = req[k] ? lowest : '0;
      assign free_at[k+1]  = free_at[k] & ~pick;
      assign grant[k]      = pick;
      assign sig_ok[k]     = |pick;
      assign sig_pin[k]    = oh_index(pick);
      assign miss[k]       = req[k] & ~(|free_at[k]);
   end

   assign starved = |miss;
endmodule

// File: rtl/pxb_pin_view.sv
module pxb_pin_view
   import pxb_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24
)(
   input  logic [SIG_COUNT-1:0][NUM_PINS-1:0] grant,
   output logic [NUM_PINS-1:0][SRC_W-1:0]     pin_src,
   output logic [NUM_PINS-1:0]                pin_ok
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      always_comb begin
         pin_ok[p]  = 1'b0;
         pin_src[p] = SRC_NONE;
         for (int k = 0; k < SIG_COUNT; k++) begin
            if (grant[k][p]) begin
               pin_ok[p]  = 1'b1;
               pin_src[p] = SRC_W'(k);
            end
         end
      end
   end
endmodule

// File: rtl/pxb_out_reg.sv
module pxb_out_reg
   import pxb_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned PIN_W    = 5
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PINS-1:0][SRC_W-1:0]  pin_src_d,
   input  logic [NUM_PINS-1:0]             pin_ok_d,
   input  logic [SIG_COUNT-1:0][PIN_W-1:0] sig_pin_d,
   input  logic [SIG_COUNT-1:0]            sig_ok_d,
   input  logic                            ovf_d,
   output logic [NUM_PINS-1:0][SRC_W-1:0]  pin_src_q,
   output logic [NUM_PINS-1:0]             pin_ok_q,
   output logic [SIG_COUNT-1:0][PIN_W-1:0] sig_pin_q,
   output logic [SIG_COUNT-1:0]            sig_ok_q,
   output logic                            ovf_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_src_q <= {NUM_PINS{SRC_NONE}};
         pin_ok_q  <= '0;
         sig_pin_q <= '0;
         sig_ok_q  <= '0;
         ovf_q     <= 1'b0;
      end else begin
         pin_src_q <= pin_src_d;
         pin_ok_q  <= pin_ok_d;
         sig_pin_q <= sig_pin_d;
         sig_ok_q  <= sig_ok_d;
         ovf_q     <= ovf_d;
      end
   end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
   import pxb_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned PORT_W    = 8,
   parameter logic [NUM_PORTS*PORT_W-1:0] ABSENT_PINS = '0,
   localparam int unsigned NUM_PINS = NUM_PORTS * PORT_W,
   localparam int unsigned PIN_W    = $clog2(NUM_PINS)
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               xbar_en,
   input  logic                               uart_en,
   input  logic                               spi_en,
   input  logic                               spi_4wire,
   input  logic                               i2c_en,
   input  logic                               cmp_en,
   input  logic                               cmp_async_en,
   input  logic                               clkout_en,
   input  logic [1:0]                         pwm_cnt,
   input  logic                               cnt_clk_en,
   input  logic                               tmr0_en,
   input  logic                               tmr1_en,
   input  logic [NUM_PORTS-1:0][PORT_W-1:0]   skip_mask,
   output logic [NUM_PINS-1:0][SRC_W-1:0]     pin_src,
   output logic [NUM_PINS-1:0]                pin_valid,
   output logic [SIG_COUNT-1:0][PIN_W-1:0]    sig_pin,
   output logic [SIG_COUNT-1:0]               sig_valid,
   output logic                               overflow
);
   if (NUM_PINS < 2) begin : g_err_small
      $error("pin_crossbar: at least two pins are required");
   end
   if (NUM_PINS > 64) begin : g_err_large
      $error("pin_crossbar: more than 64 pins not supported");
   end
   if ((1 << SRC_W) <= SIG_COUNT) begin : g_err_src
      $error("pin_crossbar: source index too narrow for the free code");
   end

   logic [SIG_COUNT-1:0]                 req;
   logic [NUM_PINS-1:0]                  avail;
   logic [SIG_COUNT-1:0][NUM_PINS-1:0]   grant;
   logic [SIG_COUNT-1:0][PIN_W-1:0]      sig_pin_c;
   logic [SIG_COUNT-1:0]                 sig_ok_c;
   logic [NUM_PINS-1:0][SRC_W-1:0]       pin_src_c;
   logic [NUM_PINS-1:0]                  pin_ok_c;
   logic                                 ovf_c;

   assign avail = ~skip_mask & ~ABSENT_PINS;

   pxb_req_decode u_decode (
      .xbar_en      (xbar_en),
      .uart_en      (uart_en),
      .spi_en       (spi_en),
      .spi_4wire    (spi_4wire),
      .i2c_en       (i2c_en),
      .cmp_en       (cmp_en),
      .cmp_async_en (cmp_async_en),
      .clkout_en    (clkout_en),
      .pwm_cnt      (pwm_cnt),
      .cnt_clk_en   (cnt_clk_en),
      .tmr0_en      (tmr0_en),
      .tmr1_en      (tmr1_en),
      .req          (req)
   );

   pxb_alloc #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_alloc (
      .req     (req),
      .avail   (avail),
      .grant   (grant),
      .sig_pin (sig_pin_c),
      .sig_ok  (sig_ok_c),
      .starved (ovf_c)
   );

   pxb_pin_view #(.NUM_PINS(NUM_PINS)) u_pin_view (
      .grant   (grant),
      .pin_src (pin_src_c),
      .pin_ok  (pin_ok_c)
   );

   pxb_out_reg #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_out_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_src_d (pin_src_c),
      .pin_ok_d  (pin_ok_c),
      .sig_pin_d (sig_pin_c),
      .sig_ok_d  (sig_ok_c),
      .ovf_d     (ovf_c),
      .pin_src_q (pin_src),
      .pin_ok_q  (pin_valid),
      .sig_pin_q (sig_pin),
      .sig_ok_q  (sig_valid),
      .ovf_q     (overflow)
   );
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker
   import pxb_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned PORT_W    = 8,
   parameter logic [NUM_PORTS*PORT_W-1:0] ABSENT_PINS = '0,
   localparam int unsigned NUM_PINS = NUM_PORTS * PORT_W,
   localparam int unsigned PIN_W    = $clog2(NUM_PINS)
)(
   input logic                             clk,
   input logic                             rst_n,
   input logic                             xbar_en,
   input logic                             spi_4wire,
   input logic [NUM_PORTS-1:0][PORT_W-1:0] skip_mask,
   input logic [NUM_PINS-1:0][SRC_W-1:0]   pin_src,
   input logic [NUM_PINS-1:0]              pin_valid,
   input logic [SIG_COUNT-1:0][PIN_W-1:0]  sig_pin,
   input logic [SIG_COUNT-1:0]             sig_valid,
   input logic                             overflow
);
   logic [NUM_PINS-1:0] skip_flat;
   assign skip_flat = skip_mask;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
      AST_PIN_POINTS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
         pin_valid[p] |-> (sig_valid[pin_src[p]] && sig_pin[pin_src[p]] == PIN_W'(p))); // R11
      AST_FREE_PIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
         !pin_valid[p] |-> (pin_src[p] == SRC_NONE)); // R8
   end

   for (genvar k = 0; k < SIG_COUNT; k++) begin : g_sig_chk
      AST_SIG_POINTS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
         sig_valid[k] |-> (pin_valid[sig_pin[k]] && pin_src[sig_pin[k]] == SRC_W'(k))); // R11
      for (genvar j = k + 1; j < SIG_COUNT; j++) begin : g_pair
         AST_PRIORITY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (sig_valid[k] && sig_valid[j]) |-> (sig_pin[k] < sig_pin[j])); // R1
      end
   end

   AST_SKIP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pin_valid & $past(skip_flat)) == '0)); // R3
   AST_ABSENT_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_valid & ABSENT_PINS) == '0); // R4
   AST_SEL_3WIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_4wire |=> !sig_valid[SIG_SPI_SEL]); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!overflow || ((pin_valid | $past(skip_flat) | ABSENT_PINS) == '1))); // R7
   AST_XBAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !xbar_en |=> (pin_valid == '0 && sig_valid == '0 && !overflow)); // R10
endmodule

bind pin_crossbar pxb_checker #(
   .NUM_PORTS   (NUM_PORTS),
   .PORT_W      (PORT_W),
   .ABSENT_PINS (ABSENT_PINS)
) u_pxb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .xbar_en   (xbar_en),
   .spi_4wire (spi_4wire),
   .skip_mask (skip_mask),
   .pin_src   (pin_src),
   .pin_valid (pin_valid),
   .sig_pin   (sig_pin),
   .sig_valid (sig_valid),
   .overflow  (overflow)
);

// File: tb/pin_crossbar_bench.sv
`timescale 1ns/1ps
module pin_crossbar_bench;
   localparam int NP = 24;
   localparam int NS = 17;
   localparam logic [23:0] ABS = 24'h7F_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xbar_en = 0, uart_en = 0, spi_en = 0, spi_4wire = 0, i2c_en = 0;
   logic cmp_en = 0, cmp_async_en = 0, clkout_en = 0, cnt_clk_en = 0;
   logic tmr0_en = 0, tmr1_en = 0;
   logic [1:0] pwm_cnt = 2'd0;
   logic [2:0][7:0] skip = '0;
   logic [NP-1:0][4:0] pin_src;
   logic [NP-1:0]      pin_valid;
   logic [NS-1:0][4:0] sig_pin;
   logic [NS-1:0]      sig_valid;
   logic               overflow;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;
   bit done = 0;

   int exp_pin_src [NP];
   bit exp_pin_ok  [NP];
   int exp_sig_pin [NS];
   bit exp_sig_ok  [NS];
   bit exp_ovf;

   always #2 clk = ~clk;

   pin_crossbar #(.ABSENT_PINS(ABS)) u_pin_crossbar (
      .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .uart_en(uart_en),
      .spi_en(spi_en), .spi_4wire(spi_4wire), .i2c_en(i2c_en),
      .cmp_en(cmp_en), .cmp_async_en(cmp_async_en), .clkout_en(clkout_en),
      .pwm_cnt(pwm_cnt), .cnt_clk_en(cnt_clk_en), .tmr0_en(tmr0_en),
      .tmr1_en(tmr1_en), .skip_mask(skip), .pin_src(pin_src),
      .pin_valid(pin_valid), .sig_pin(sig_pin), .sig_valid(sig_valid),
      .overflow(overflow)
   );

   // Reference: a cursor walks up the pins; each wanting signal takes the next usable one.
   task automatic model_eval(input bit in_reset);
      bit want [NS];
      int cur;
      for (int p = 0; p < NP; p++) begin exp_pin_src[p] = 31; exp_pin_ok[p] = 0; end
      for (int k = 0; k < NS; k++) begin exp_sig_pin[k] = 0; exp_sig_ok[k] = 0; end
      exp_ovf = 0;
      if (in_reset || !xbar_en) return;
      want[0] = uart_en;  want[1] = uart_en;
      want[2] = spi_en;   want[3] = spi_en; want[4] = spi_en;
      want[5] = spi_en && spi_4wire;
      want[6] = i2c_en;   want[7] = i2c_en;
      want[8] = cmp_en;   want[9] = cmp_async_en; want[10] = clkout_en;
      want[11] = pwm_cnt > 0; want[12] = pwm_cnt > 1; want[13] = pwm_cnt > 2;
      want[14] = cnt_clk_en; want[15] = tmr0_en; want[16] = tmr1_en;
      cur = 0;
      for (int k = 0; k < NS; k++) begin
         if (!want[k]) continue;
         while (cur < NP && (skip[cur/8][cur%8] || ABS[cur])) cur++;
         if (cur < NP) begin
            exp_sig_pin[k] = cur; exp_sig_ok[k] = 1;
            exp_pin_src[cur] = k; exp_pin_ok[cur] = 1;
            cur++;
         end else begin
            exp_ovf = 1;
         end
      end
   endtask

   always @(posedge clk or negedge rst_n) model_eval(!rst_n);

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         bit bad_pin, bad_sig;
         int bp, bs;
         bad_pin = 0; bad_sig = 0; bp = 0; bs = 0;
         for (int p = 0; p < NP; p++)
            if (!bad_pin && (pin_valid[p] != exp_pin_ok[p] || int'(pin_src[p]) != exp_pin_src[p])) begin
               bad_pin = 1; bp = p;
            end
         for (int k = 0; k < NS; k++)
            if (!bad_sig && (sig_valid[k] != exp_sig_ok[k] || int'(sig_pin[k]) != exp_sig_pin[k])) begin
               bad_sig = 1; bs = k;
            end
         checks += 3;
         if (bad_pin) begin
            errors++;
            $display("FAIL R2 pin %0d: actual src=%0d v=%0d expected src=%0d v=%0d",
                     bp, pin_src[bp], pin_valid[bp], exp_pin_src[bp], exp_pin_ok[bp]);
         end
         if (bad_sig) begin
            errors++;
            $display("FAIL R1 signal %0d: actual pin=%0d v=%0d expected pin=%0d v=%0d",
                     bs, sig_pin[bs], sig_valid[bs], exp_sig_pin[bs], exp_sig_ok[bs]);
         end
         if (overflow != exp_ovf) begin
            errors++;
            $display("FAIL R7 overflow: actual=%0d expected=%0d", overflow, exp_ovf);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_all();
      uart_en = 0; spi_en = 0; spi_4wire = 0; i2c_en = 0; cmp_en = 0;
      cmp_async_en = 0; clkout_en = 0; pwm_cnt = 0; cnt_clk_en = 0;
      tmr0_en = 0; tmr1_en = 0; skip = '0;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk); @(negedge clk);
      xbar_en = 1; uart_en = 1;
      @(negedge clk);
      // R9 reset state holds despite active inputs
      check_val("R9 reset pin_valid", int'(pin_valid), 0);
      check_val("R9 reset sig_valid", int'(sig_valid), 0);
      check_val("R9 reset overflow", int'(overflow), 0);
      check_val("R8 reset free code", int'(pin_src[0]), 31);
      rst_n = 1;
      cmp_on = 1;
      tick();
      check_val("R1 uart tx pin", int'(sig_pin[0]), 0);
      check_val("R1 uart rx pin", int'(sig_pin[1]), 1);
      check_val("R11 pin1 src", int'(pin_src[1]), 1);
      skip[0] = 8'h03;
      tick();
      check_val("R3 tx after skip", int'(sig_pin[0]), 2);
      check_val("R3 skipped pin0 free", int'(pin_valid[0]), 0);
      spi_en = 1; spi_4wire = 0;
      tick();
      check_val("R5 sel 3-wire invalid", int'(sig_valid[5]), 0);
      check_val("R5 mosi pin", int'(sig_pin[4]), 6);
      spi_4wire = 1;
      tick();
      check_val("R5 sel 4-wire pin", int'(sig_pin[5]), 7);
      i2c_en = 1;
      tick();
      check_val("R2 sda crosses to port 1", int'(sig_pin[6]), 8);
      check_val("R2 scl pin", int'(sig_pin[7]), 9);
      uart_en = 0;
      #1;
      check_val("R9 no change before edge", int'(sig_valid[0]), 1);
      tick();
      check_val("R6 tx released", int'(sig_valid[0]), 0);
      check_val("R6 spi clk moved up", int'(sig_pin[2]), 2);
      clear_all(); pwm_cnt = 2;
      tick();
      check_val("R6 pwm0 pin", int'(sig_pin[11]), 0);
      check_val("R6 pwm1 pin", int'(sig_pin[12]), 1);
      check_val("R6 pwm2 unused", int'(sig_valid[13]), 0);
      uart_en = 1; spi_en = 1; spi_4wire = 1; i2c_en = 1; cmp_en = 1;
      cmp_async_en = 1; clkout_en = 1; pwm_cnt = 3; cnt_clk_en = 1;
      tmr0_en = 1; tmr1_en = 1; skip[0] = 8'hFF;
      tick();
      check_val("R4 absent pins skipped", int'(sig_pin[8]), 23);
      check_val("R4 absent pin16 free", int'(pin_valid[16]), 0);
      check_val("R7 sig9 no pin", int'(sig_valid[9]), 0);
      check_val("R7 overflow", int'(overflow), 1);
      xbar_en = 0;
      tick();
      check_val("R10 off pins", int'(pin_valid), 0);
      check_val("R10 off overflow", int'(overflow), 0);
      check_val("R8 free code", int'(pin_src[8]), 31);
      for (int i = 0; i < 1500; i++) begin
         xbar_en = ($urandom % 8) != 0;
         uart_en = $urandom; spi_en = $urandom; spi_4wire = $urandom;
         i2c_en = $urandom; cmp_en = $urandom; cmp_async_en = $urandom;
         clkout_en = $urandom; pwm_cnt = $urandom; cnt_clk_en = $urandom;
         tmr0_en = $urandom; tmr1_en = $urandom;
         for (int q = 0; q < 3; q++) skip[q] = 8'($urandom & $urandom & $urandom);
         if (i % 5 == 0) skip = '1;
         tick();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule